// File: doc/BRIEF.md
# Quadrature-Locked Digital Sine Synthesizer

This block produces a digital sinewave whose frequency is set by a tuning word. It also produces two square sampling clocks that are locked to that sinewave. On every enabled clock cycle a phase register advances by the tuning word, modulo one full turn. The phase then addresses a sine table, and the table returns an offset-binary amplitude word that can drive an unsigned resistor-ladder DAC directly. The output frequency is tune / 2^PHASE_W times the clock rate. The highest useful tone sits at half the clock rate.

The same phase value is decoded by quadrant into an in-phase level and a quadrature level, which sit a quarter turn apart. Downstream samplers use them to capture the two orthogonal components of a response at exactly the stimulus frequency. The amplitude word and both levels are captured in one output register stage. They therefore change together and never glitch.

Top module: `ddfs_quad`

## Requirements
- R1: An active-low reset, applied asynchronously, forces the phase to 0 and the outputs to the phase-0 values: sample = 512, clk_i = 1, clk_q = 0. After release, stepping starts again from phase 0.
- R2: When en is high at a clock edge, the phase p becomes (p + tune) mod 1024. The outputs after an edge reflect the phase held just before that edge, so they lag the phase register by one cycle.
- R3: sample is offset binary, with zero amplitude at code 512. It equals 512 + round(511·sin(2π·p/1024)) to within one code.
- R4: clk_i is 1 exactly when p lies in [0, 512), which is the first half turn.
- R5: clk_q is 1 exactly when p lies in [256, 768), so it lags clk_i by a quarter turn.
- R6: When en is low, the phase holds, and sample, clk_i and clk_q stay constant.
- R7: A tuning word of 0 with en high holds the phase, and all outputs stay constant.
- R8: tune = 512, which is half the clock rate, makes clk_i toggle on every cycle. tune = 256 gives clk_i a period of 4 cycles.
- R9: The wave is exactly antisymmetric: sample(p) + sample(p+512) = 1024 for every p. The codes are exact at the extremes: 512 at p = 0 and p = 512, 1023 at p = 256, and 1 at p = 768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synthesizer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Advance enable for the phase register |
| tune | input | PHASE_W (10) | Phase step added per enabled cycle |
| sample | output | AMP_W (10) | Offset-binary sine amplitude |
| clk_i | output | 1 | In-phase square clock, high on the first half turn |
| clk_q | output | 1 | Quadrature square clock, high from a quarter to three quarters of a turn |

## Verification
The checker assumes that en and tune are steady around each rising edge. It also assumes that reset is held for at least one full clock period, so the internally synchronized reset clears every register before the checker's disable condition lifts. The bench changes inputs only on the falling edge and holds en low for several cycles after releasing reset. Because of this, the two-flop reset release never overlaps a phase step. The sweeps then cover every phase value with tune = 1, plus wrap-around strides, the reverse stride 1023, and the Nyquist and quarter-rate words.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

  typedef enum logic [1:0] {
    QD_RISE = 2'd0,
    QD_CREST = 2'd1,
    QD_FALL = 2'd2,
    QD_TROUGH = 2'd3
  } quadrant_e;

  localparam real HALF_PI = 1.5707963267948966;

  // Odd power series for sin(x) on [0, pi/2]; evaluated only at elaboration.
  function automatic real series_sin(input real x);
    real term;
    real acc;
    term = x;
    acc = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc = acc + term;
    end
    return acc;
  endfunction

endpackage

// File: rtl/ddfs_rst_sync.sv
module ddfs_rst_sync (
  input  logic clk,
  input  logic rst_an_i,
  output logic rst_an_o
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_an_i) begin
    if (!rst_an_i) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_an_o = hold_q;
endmodule

// File: rtl/ddfs_phase_acc.sv
module ddfs_phase_acc #(
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] tune,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] phase_r;

  always_comb begin
    phase_d = phase_r;
    if (en) begin
      phase_d = phase_r + tune;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r <= '0;
    end else begin
      phase_r <= phase_d;
    end
  end

  assign phase = phase_r;
endmodule

// File: rtl/ddfs_sine_lut.sv
module ddfs_sine_lut #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 10
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [AMP_W-1:0]   sample
);
  import ddfs_pkg::*;

  localparam int QBITS   = PHASE_W - 2;
  localparam int QN      = 1 << QBITS;
  localparam int MAGW    = AMP_W - 1;
  localparam int MAG_MAX = (1 << MAGW) - 1;
  localparam int TBITS   = (QN + 1) * MAGW;
  localparam logic [QBITS:0] QN_IDX = (QBITS + 1)'(QN);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << MAGW);

  function automatic logic [TBITS-1:0] build_quarter();
    logic [TBITS-1:0] t;
    real ang;
    real v;
    int m;
    t = '0;
    for (int i = 0; i <= QN; i++) begin
      ang = HALF_PI * real'(i) / real'(QN);
      v = real'(MAG_MAX) * series_sin(ang);
      m = $rtoi(v + 0.5);
      if (m > MAG_MAX) m = MAG_MAX;
      if (m < 0) m = 0;
      t[i*MAGW +: MAGW] = MAGW'(m);
    end
    return t;
  endfunction

  localparam logic [TBITS-1:0] QTAB = build_quarter();

  quadrant_e        quad;
  logic [QBITS-1:0] frac;
  logic [QBITS:0]   idx;
  logic [MAGW-1:0]  mag;

  always_comb begin
    quad = quadrant_e'(phase[PHASE_W-1 -: 2]);
    frac = phase[QBITS-1:0];
    if (quad == QD_CREST || quad == QD_TROUGH) begin
      idx = QN_IDX - {1'b0, frac};
    end else begin
      idx = {1'b0, frac};
    end
    mag = QTAB[idx*MAGW +: MAGW];
    if (quad == QD_FALL || quad == QD_TROUGH) begin
      sample = MID - {1'b0, mag};
    end else begin
      sample = MID + {1'b0, mag};
    end
  end
endmodule

// File: rtl/ddfs_quadrant_decode.sv
module ddfs_quadrant_decode (
  input  logic [1:0] quad_bits,
  output logic       lvl_i,
  output logic       lvl_q
);
  import ddfs_pkg::*;

  quadrant_e quad;

  always_comb begin
    quad = quadrant_e'(quad_bits);
    unique case (quad)
      QD_RISE:   begin lvl_i = 1'b1; lvl_q = 1'b0; end
      QD_CREST:  begin lvl_i = 1'b1; lvl_q = 1'b1; end
      QD_FALL:   begin lvl_i = 1'b0; lvl_q = 1'b1; end
      QD_TROUGH: begin lvl_i = 1'b0; lvl_q = 1'b0; end
      default:   begin lvl_i = 1'b0; lvl_q = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ddfs_quad.sv
module ddfs_quad #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] tune,
  output logic [AMP_W-1:0]   sample,
  output logic               clk_i,
  output logic               clk_q
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic               rst_core_n;
  logic [PHASE_W-1:0] phase_q;
  logic [AMP_W-1:0]   lut_word;
  logic               lvl_i;
  logic               lvl_q;

  logic [AMP_W-1:0]   sample_d;
  logic [AMP_W-1:0]   sample_r;
  logic               clk_i_d;
  logic               clk_i_r;
  logic               clk_q_d;
  logic               clk_q_r;

  ddfs_rst_sync u_rst (
    .clk      (clk),
    .rst_an_i (rst_n),
    .rst_an_o (rst_core_n)
  );

  ddfs_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (en),
    .tune  (tune),
    .phase (phase_q)
  );

  ddfs_sine_lut #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_lut (
    .phase  (phase_q),
    .sample (lut_word)
  );

  ddfs_quadrant_decode u_quad (
    .quad_bits (phase_q[PHASE_W-1 -: 2]),
    .lvl_i     (lvl_i),
    .lvl_q     (lvl_q)
  );

  always_comb begin
    sample_d = lut_word;
    clk_i_d  = lvl_i;
    clk_q_d  = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sample_r <= MID;
      clk_i_r  <= 1'b1;
      clk_q_r  <= 1'b0;
    end else begin
      sample_r <= sample_d;
      clk_i_r  <= clk_i_d;
      clk_q_r  <= clk_q_d;
    end
  end

  assign sample = sample_r;
  assign clk_i  = clk_i_r;
  assign clk_q  = clk_q_r;
endmodule

// File: rtl/ddfs_quad_chk.sv
module ddfs_quad_chk #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [PHASE_W-1:0] tune,
  input logic [AMP_W-1:0]   sample,
  input logic               clk_i,
  input logic               clk_q,
  input logic [PHASE_W-1:0] phase
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  // R4
  iclk_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_i == !$past(phase[PHASE_W-1]));

  // R5
  qclk_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q == ($past(phase[PHASE_W-1]) ^ $past(phase[PHASE_W-2])));

  // R3
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_i |-> sample >= MID);

  // R3
  lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_i |-> sample <= MID);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(phase));

  // R7
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tune == '0) |=> $stable(phase));

  // R7
  still_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(phase) |=> ($stable(sample) && $stable(clk_i) && $stable(clk_q)));
endmodule

bind ddfs_quad ddfs_quad_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .tune   (tune),
  .sample (sample),
  .clk_i  (clk_i),
  .clk_q  (clk_q),
  .phase  (phase_q)
);

// File: tb/ddfs_quad_test.sv
module ddfs_quad_test;
  localparam int PW   = 10;
  localparam int AW   = 10;
  localparam int NPH  = 1 << PW;
  localparam int MID  = 512;
  localparam int AMAX = 511;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [PW-1:0] tune = '0;
  logic [AW-1:0] sample;
  logic          clk_i;
  logic          clk_q;

  int n_chk = 0;
  int n_fail = 0;
  int ph = 0;
  int out_ph = 0;
  int got [NPH];

  always #5 clk = ~clk;

  ddfs_quad #(.PHASE_W(PW), .AMP_W(AW)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .tune   (tune),
    .sample (sample),
    .clk_i  (clk_i),
    .clk_q  (clk_q)
  );

  function automatic int ideal_sample(input int p);
    real v;
    int r;
    v = real'(AMAX) * $sin(2.0 * 3.14159265358979 * real'(p) / real'(NPH));
    if (v >= 0.0) r = $rtoi(v + 0.5);
    else r = -$rtoi(-v + 0.5);
    return MID + r;
  endfunction

  task automatic expect_int(input string tag, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    expect_int({tag, " R3 sample"}, int'(sample), ideal_sample(out_ph), 1);
    expect_int({tag, " R4 clk_i"}, int'(clk_i), (out_ph < 512) ? 1 : 0, 0);
    expect_int({tag, " R5 clk_q"}, int'(clk_q), (out_ph >= 256 && out_ph < 768) ? 1 : 0, 0);
  endtask

  task automatic tick();
    @(posedge clk);
    out_ph = ph;
    if (en) ph = (ph + int'(tune)) % NPH;
    @(negedge clk);
  endtask

  task automatic run(input int k, input int n, input string tag);
    tune = PW'(k);
    en = 1'b1;
    for (int c = 0; c < n; c++) begin
      tick();
      check_outs(tag);
    end
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int prev;
    int rises;
    logic [AW-1:0] held_s;
    logic held_i;
    logic held_q;

    repeat (3) @(negedge clk);
    // R1 reset values while reset is held
    expect_int("R1 reset sample", int'(sample), 512, 0);
    expect_int("R1 reset clk_i", int'(clk_i), 1, 0);
    expect_int("R1 reset clk_q", int'(clk_q), 0, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      tick();
      check_outs("R1 post-release");
    end

    // R2 full sweep with unit step, capture every phase
    tune = 10'd1;
    en = 1'b1;
    for (int c = 0; c < NPH + 2; c++) begin
      tick();
      check_outs("R2 step1");
      got[out_ph] = int'(sample);
    end

    // R9 antisymmetry and exact extremes
    for (int p = 0; p < NPH / 2; p++) begin
      expect_int("R9 antisymmetry", got[p] + got[p + NPH / 2], 1024, 0);
    end
    expect_int("R9 code at 0", got[0], 512, 0);
    expect_int("R9 code at 256", got[256], 1023, 0);
    expect_int("R9 code at 512", got[512], 512, 0);
    expect_int("R9 code at 768", got[768], 1, 0);

    // R2 wrap-around strides, forward and reverse
    run(3, 700, "R2 step3");
    run(1023, 300, "R2 step1023");
    run(37, 200, "R2 step37");

    // R8 Nyquist word toggles clk_i every cycle
    run(512, 2, "R8 setup");
    prev = int'(clk_i);
    for (int c = 0; c < 16; c++) begin
      tick();
      check_outs("R8 nyquist");
      expect_int("R8 toggle", int'(clk_i), 1 - prev, 0);
      prev = int'(clk_i);
    end

    // R8 quarter-rate word: period of 4 cycles
    run(256, 2, "R8 setup");
    rises = 0;
    prev = int'(clk_i);
    for (int c = 0; c < 64; c++) begin
      tick();
      check_outs("R8 quarter");
      if (clk_i && prev == 0) rises++;
      prev = int'(clk_i);
    end
    expect_int("R8 quarter rises", rises, 16, 0);

    // R6 enable low holds everything
    run(5, 50, "R6 pre");
    tune = 10'd5;
    en = 1'b0;
    tick();
    held_s = sample;
    held_i = clk_i;
    held_q = clk_q;
    for (int c = 0; c < 20; c++) begin
      tick();
      check_outs("R6 idle");
      expect_int("R6 sample held", int'(sample), int'(held_s), 0);
      expect_int("R6 clk_i held", int'(clk_i), int'(held_i), 0);
      expect_int("R6 clk_q held", int'(clk_q), int'(held_q), 0);
    end

    // R7 zero tuning word holds everything
    run(0, 2, "R7 setup");
    held_s = sample;
    held_i = clk_i;
    held_q = clk_q;
    for (int c = 0; c < 20; c++) begin
      tick();
      check_outs("R7 zero");
      expect_int("R7 sample held", int'(sample), int'(held_s), 0);
      expect_int("R7 clk_i held", int'(clk_i), int'(held_i), 0);
      expect_int("R7 clk_q held", int'(clk_q), int'(held_q), 0);
    end

    // R1 asynchronous reset in the middle of a run
    run(7, 100, "R2 step7");
    #2;
    rst_n = 1'b0;
    #1;
    expect_int("R1 async sample", int'(sample), 512, 0);
    expect_int("R1 async clk_i", int'(clk_i), 1, 0);
    expect_int("R1 async clk_q", int'(clk_q), 0, 0);
    en = 1'b0;
    ph = 0;
    out_ph = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      tick();
      check_outs("R1 re-release");
    end
    run(11, 200, "R1 resume");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule